// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block decides what happens when a small microcontroller core executes its power-down instruction. On the decode strobe it looks at the synchronised interrupt flags, masked by their enables. If any enabled source is already pending, the instruction retires as a no-op and nothing changes. Otherwise the block enters sleep. On that entry it pulses a watchdog clear, which also clears the postscaler; the watchdog itself keeps counting. It also lowers the power-down status bit, raises the time-out status bit, drops the main oscillator enable and stalls the core.

While asleep it watches three inputs: the watchdog time-out, the enabled interrupt flags and the external reset pin. All three are brought in through synchronisers clocked by an always-on low-rate clock, so nothing depends on the gated main clock. An interrupt or watchdog wake restarts the oscillator. The core stays stalled for a fixed start-up time, after which one resume pulse is issued. Together with the pulse, a vector flag tells the core what to do next. When the flag is low, the core simply continues with the prefetched next instruction. When it is high, the core executes that instruction and then branches to its interrupt address (0x0004). An interrupt wakes the device whatever the global enable, and the vector flag copies the global enable. A watchdog wake never vectors. An external reset is not a wake-up: it holds the core in reset until the pin is released.

The watchdog counter, the interrupt sources and the program counter are outside the block.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset: osc_en=1, stat_pd=1, stat_to=1, core_stall=0, core_resume=0, core_rst=0, wdt_clr=0.
- R2: A sleep strobe with no pending enabled interrupt enters sleep at the next clock edge: osc_en=0, core_stall=1, stat_pd=0, stat_to=1, and wdt_clr is high for exactly one cycle.
- R3: If some bit with irq_flag[i]&irq_en[i]=1 has passed the synchroniser when the strobe is seen, the instruction is a no-op: osc_en stays 1, core_stall stays 0, wdt_clr stays 0, and stat_pd and stat_to keep their values.
- R4: A flag whose enable bit is 0 does not wake the block; osc_en stays 0 while asleep.
- R5: An enabled interrupt wakes the block regardless of gie. resume_vector equals gie as sampled at the wake, and stat_to is unchanged.
- R6: A watchdog time-out while asleep wakes the block with stat_to=0 and resume_vector=0. It takes priority over an interrupt that arrives at the same time.
- R7: A flag that arrives in the same cycle as the strobe cannot turn the instruction into a no-op. Sleep is fully entered (wdt_clr pulse, stat_pd=0) and is followed at once by a wake.
- R8: After a wake, osc_en=1 and core_stall=1 for exactly STARTUP_CYCLES cycles. A single-cycle core_resume then follows, with core_stall=0.
- R9: A low level on mclr_n forces core_rst=1, osc_en=1 and core_stall=0 with no core_resume. stat_pd and stat_to keep their values. After release, core_rst returns to 0.
- R10: stat_pd is set only by power-on reset and cleared only by sleep entry. wdt_timeout while awake changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_strobe | input | 1 | One-cycle decode of the sleep instruction |
| irq_flag | input | NUM_IRQ | Interrupt flags, asynchronous |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out, asynchronous |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| osc_en | output | 1 | Main oscillator enable |
| wdt_clr | output | 1 | One-cycle watchdog and postscaler clear |
| stat_pd | output | 1 | Power-down status bit |
| stat_to | output | 1 | Time-out status bit |
| core_stall | output | 1 | Holds the core while asleep or starting up |
| core_resume | output | 1 | One-cycle resume pulse |
| resume_vector | output | 1 | 1: branch to interrupt address after next instruction |
| core_rst | output | 1 | Core reset from the external pin |

## Verification
The bench builds the block with NUM_IRQ=4, SYNC_STAGES=2 and STARTUP_CYCLES=5. With a short start-up window, the exact count of stalled, oscillator-on cycles before every resume can be checked on each wake. The two-stage synchroniser makes the race between a late flag and the strobe reproducible at a known edge. Four sources are enough to exercise the masked flag, the pending no-op, wakes with each global-enable state, and a watchdog wake arriving alongside an interrupt.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE   = 2'd0,
        ST_ASLEEP  = 2'd1,
        ST_STARTUP = 2'd2,
        ST_RSTHOLD = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_WDT  = 2'd1,
        WK_IRQ  = 2'd2
    } wake_cause_e;

    typedef struct packed {
        pm_state_e state;
        logic      osc_en;
        logic      wdt_clr;
        logic      pd;
        logic      to;
        logic      stall;
        logic      resume;
        logic      vector;
        logic      core_rst;
    } pm_regs_t;

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import sleep_wake_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] flag_s,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               wdt_s,
    output logic               irq_pend,
    output wake_cause_e        cause
);
    logic [NUM_IRQ-1:0] armed;

    always_comb begin
        armed    = flag_s & irq_en;
        irq_pend = |armed;
        if (wdt_s)         cause = WK_WDT;
        else if (irq_pend) cause = WK_IRQ;
        else               cause = WK_NONE;
    end
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
    parameter int STARTUP_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STARTUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load) begin
            cnt_d = LOAD_VAL;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import sleep_wake_pkg::*;
#(
    parameter int NUM_IRQ        = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int STARTUP_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sleep_strobe,
    input  logic [NUM_IRQ-1:0] irq_flag,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               gie,
    input  logic               wdt_timeout,
    input  logic               mclr_n,
    output logic               osc_en,
    output logic               wdt_clr,
    output logic               stat_pd,
    output logic               stat_to,
    output logic               core_stall,
    output logic               core_resume,
    output logic               resume_vector,
    output logic               core_rst
);
    localparam int ASYNC_W = NUM_IRQ + 2;

    logic [ASYNC_W-1:0] async_raw, async_s;
    logic [NUM_IRQ-1:0] flag_s;
    logic               wdt_s, mclr_s;
    logic               irq_pend;
    wake_cause_e        cause;
    logic               timer_load, timer_done;
    pm_regs_t           r_d, r_q;

    // flags reset low, watchdog low, reset pin high (released)
    assign async_raw = {mclr_n, wdt_timeout, irq_flag};

    sync_bits #(
        .WIDTH   (ASYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {(ASYNC_W-1){1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .din   (async_raw),
        .dout  (async_s)
    );

    assign flag_s = async_s[NUM_IRQ-1:0];
    assign wdt_s  = async_s[NUM_IRQ];
    assign mclr_s = async_s[NUM_IRQ+1];

    wake_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
        .flag_s   (flag_s),
        .irq_en   (irq_en),
        .wdt_s    (wdt_s),
        .irq_pend (irq_pend),
        .cause    (cause)
    );

    startup_timer #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (por_n),
        .load  (timer_load),
        .done  (timer_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.wdt_clr = 1'b0;
        r_d.resume = 1'b0;
        timer_load = 1'b0;
        if (!mclr_s) begin
            r_d.state    = ST_RSTHOLD;
            r_d.core_rst = 1'b1;
            r_d.osc_en   = 1'b1;
            r_d.stall    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_AWAKE: begin
                    // decision is taken on the synchronised view at the strobe
                    if (sleep_strobe && !irq_pend) begin
                        r_d.state   = ST_ASLEEP;
                        r_d.osc_en  = 1'b0;
                        r_d.stall   = 1'b1;
                        r_d.wdt_clr = 1'b1;
                        r_d.pd      = 1'b0;
                        r_d.to      = 1'b1;
                    end
                end
                ST_ASLEEP: begin
                    unique case (cause)
                        WK_WDT: begin
                            r_d.state  = ST_STARTUP;
                            r_d.osc_en = 1'b1;
                            r_d.to     = 1'b0;
                            r_d.vector = 1'b0;
                            timer_load = 1'b1;
                        end
                        WK_IRQ: begin
                            r_d.state  = ST_STARTUP;
                            r_d.osc_en = 1'b1;
                            r_d.vector = gie;
                            timer_load = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_STARTUP: begin
                    if (timer_done) begin
                        r_d.state  = ST_AWAKE;
                        r_d.stall  = 1'b0;
                        r_d.resume = 1'b1;
                    end
                end
                ST_RSTHOLD: begin
                    r_d.state    = ST_AWAKE;
                    r_d.core_rst = 1'b0;
                    r_d.vector   = 1'b0;
                end
                default: r_d.state = ST_AWAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.state    <= ST_AWAKE;
            r_q.osc_en   <= 1'b1;
            r_q.wdt_clr  <= 1'b0;
            r_q.pd       <= 1'b1;
            r_q.to       <= 1'b1;
            r_q.stall    <= 1'b0;
            r_q.resume   <= 1'b0;
            r_q.vector   <= 1'b0;
            r_q.core_rst <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign osc_en        = r_q.osc_en;
    assign wdt_clr       = r_q.wdt_clr;
    assign stat_pd       = r_q.pd;
    assign stat_to       = r_q.to;
    assign core_stall    = r_q.stall;
    assign core_resume   = r_q.resume;
    assign resume_vector = r_q.vector;
    assign core_rst      = r_q.core_rst;
endmodule

// File: rtl/sleep_wake_checker.sv
module sleep_wake_checker #(
    parameter int STARTUP_CYCLES = 1024
) (
    input logic clk,
    input logic por_n,
    input logic osc_en,
    input logic wdt_clr,
    input logic stat_pd,
    input logic stat_to,
    input logic core_stall,
    input logic core_resume,
    input logic core_rst
);
    localparam int CW = $clog2(STARTUP_CYCLES + 2) + 1;
    logic [CW-1:0] warm_q;

    // cycles spent with oscillator running while the core is stalled
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                    warm_q <= '0;
        else if (osc_en && core_stall) warm_q <= (warm_q == '1) ? warm_q : warm_q + 1'b1;
        else                           warm_q <= '0;
    end

    p_entry_status_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdt_clr |-> (!stat_pd && stat_to && !osc_en));

    p_clr_pulse_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdt_clr |=> !wdt_clr);

    p_stall_when_off_r8: assert property (@(posedge clk) disable iff (!por_n)
        !osc_en |-> core_stall);

    p_startup_len_r8: assert property (@(posedge clk) disable iff (!por_n)
        core_resume |-> (warm_q == CW'(STARTUP_CYCLES)));

    p_resume_pulse_r8: assert property (@(posedge clk) disable iff (!por_n)
        core_resume |=> !core_resume);

    p_to_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(stat_to) |-> $past(!osc_en));

    p_pd_fall_r10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(stat_pd) |-> wdt_clr);

    p_pd_no_rise_r10: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(stat_pd));

    p_reset_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        core_rst |-> (osc_en && !core_stall && !core_resume));
endmodule

bind sleep_wake_ctrl sleep_wake_checker #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .osc_en      (osc_en),
    .wdt_clr     (wdt_clr),
    .stat_pd     (stat_pd),
    .stat_to     (stat_to),
    .core_stall  (core_stall),
    .core_resume (core_resume),
    .core_rst    (core_rst)
);

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;
    localparam int NI = 4;
    localparam int SU = 5;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sleep_strobe = 1'b0;
    logic [NI-1:0] irq_flag = '0;
    logic [NI-1:0] irq_en = '0;
    logic          gie = 1'b0;
    logic          wdt_timeout = 1'b0;
    logic          mclr_n = 1'b1;
    logic osc_en, wdt_clr, stat_pd, stat_to, core_stall, core_resume, resume_vector, core_rst;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.NUM_IRQ(NI), .SYNC_STAGES(2), .STARTUP_CYCLES(SU)) dut (
        .clk(clk), .por_n(por_n), .sleep_strobe(sleep_strobe), .irq_flag(irq_flag),
        .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout), .mclr_n(mclr_n),
        .osc_en(osc_en), .wdt_clr(wdt_clr), .stat_pd(stat_pd), .stat_to(stat_to),
        .core_stall(core_stall), .core_resume(core_resume),
        .resume_vector(resume_vector), .core_rst(core_rst)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); sleep_strobe = 1'b1;
        @(negedge clk); sleep_strobe = 1'b0;
    endtask

    task automatic wait_resume(input string req, input int exp_vec);
        int warm = 0;
        bit seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (core_resume) seen = 1;
            else if (core_stall && osc_en) warm++;
        end
        chk(req, "resume seen", seen, 1);
        chk("R8", "startup cycles", warm, SU);
        chk(req, "resume_vector", resume_vector, exp_vec);
        chk("R8", "stall at resume", core_stall, 0);
        @(negedge clk);
        chk("R8", "resume single pulse", core_resume, 0);
    endtask

    task automatic t_reset();
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "stat_pd", stat_pd, 1);
        chk("R1", "stat_to", stat_to, 1);
        chk("R1", "core_stall", core_stall, 0);
        chk("R1", "core_resume", core_resume, 0);
        chk("R1", "core_rst", core_rst, 0);
        chk("R1", "wdt_clr", wdt_clr, 0);
    endtask

    task automatic t_nop_pending();
        irq_flag[0] = 1'b1; irq_en[0] = 1'b1;
        idle(3);
        strobe();
        chk("R3", "osc_en", osc_en, 1);
        chk("R3", "core_stall", core_stall, 0);
        chk("R3", "wdt_clr", wdt_clr, 0);
        chk("R3", "stat_pd", stat_pd, 1);
        chk("R3", "stat_to", stat_to, 1);
        idle(1);
        chk("R3", "still awake", osc_en, 1);
        irq_flag = '0; irq_en = '0;
        idle(3);
    endtask

    task automatic t_masked_then_wake();
        gie = 1'b0;
        irq_flag[1] = 1'b1;
        idle(3);
        strobe();
        chk("R2", "osc_en", osc_en, 0);
        chk("R2", "core_stall", core_stall, 1);
        chk("R2", "stat_pd", stat_pd, 0);
        chk("R2", "stat_to", stat_to, 1);
        chk("R2", "wdt_clr", wdt_clr, 1);
        idle(1);
        chk("R2", "wdt_clr one cycle", wdt_clr, 0);
        idle(6);
        chk("R4", "masked flag keeps asleep", osc_en, 0);
        irq_en[1] = 1'b1;
        wait_resume("R5", 0);
        chk("R5", "stat_to unchanged", stat_to, 1);
        irq_flag = '0; irq_en = '0;
        idle(3);
    endtask

    task automatic t_wake_gie();
        gie = 1'b1;
        strobe();
        irq_flag[2] = 1'b1; irq_en[2] = 1'b1;
        wait_resume("R5", 1);
        irq_flag = '0; irq_en = '0; gie = 1'b0;
        idle(3);
    endtask

    task automatic t_wdt_wake();
        gie = 1'b1;
        strobe();
        idle(2);
        wdt_timeout = 1'b1;
        irq_flag[3] = 1'b1; irq_en[3] = 1'b1;
        wait_resume("R6", 0);
        chk("R6", "stat_to cleared", stat_to, 0);
        chk("R6", "stat_pd", stat_pd, 0);
        wdt_timeout = 1'b0;
        irq_flag = '0; irq_en = '0; gie = 1'b0;
        idle(3);
    endtask

    task automatic t_wdt_awake();
        wdt_timeout = 1'b1;
        idle(6);
        chk("R10", "osc_en", osc_en, 1);
        chk("R10", "core_stall", core_stall, 0);
        chk("R10", "stat_to", stat_to, 0);
        chk("R10", "stat_pd", stat_pd, 0);
        wdt_timeout = 1'b0;
        idle(3);
    endtask

    task automatic t_late_flag();
        @(negedge clk);
        sleep_strobe = 1'b1;
        irq_flag[0] = 1'b1; irq_en[0] = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
        chk("R7", "wdt_clr", wdt_clr, 1);
        chk("R7", "stat_pd", stat_pd, 0);
        chk("R7", "stat_to", stat_to, 1);
        chk("R7", "osc_en", osc_en, 0);
        wait_resume("R7", 0);
        irq_flag = '0; irq_en = '0;
        idle(3);
    endtask

    task automatic t_mclr();
        int res_seen = 0;
        strobe();
        chk("R9", "asleep", osc_en, 0);
        mclr_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (core_resume) res_seen++;
        end
        chk("R9", "core_rst", core_rst, 1);
        chk("R9", "osc_en", osc_en, 1);
        chk("R9", "core_stall", core_stall, 0);
        chk("R9", "stat_pd", stat_pd, 0);
        chk("R9", "stat_to", stat_to, 1);
        mclr_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (core_resume) res_seen++;
        end
        chk("R9", "core_rst released", core_rst, 0);
        chk("R9", "no resume", res_seen, 0);
        chk("R9", "awake", osc_en, 1);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(2);
        t_reset();
        t_nop_pending();
        t_masked_then_wake();
        t_wake_gie();
        t_wdt_wake();
        t_wdt_awake();
        t_late_flag();
        t_mclr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule